// File: doc/BRIEF.md
# Prefetch Data Change Monitor

This block watches a small set of bytes inside the register data that a prefetch engine reads again and again from a remote device. The data arrives as a stream of beats. Each beat carries a register offset and a data byte, and a separate pulse marks the close of each prefetch pass. Up to `N` monitor slots each hold a programmable offset and a bit mask. A slot fires when one of its unmasked bits was 0 in one completed pass and then read 1 in each of the next two completed passes.

When any slot fires, the block does three things. It drops its `prefetch_run` output, which tells the prefetch engine to halt. It copies the latest byte of every slot into a sampled register. It raises `irq` and records which slots fired in `src_flags`. The host reads the sampled registers through a simple select and strobe port. Reading the sampled register of a source slot clears that slot's flag, and `irq` drops once no flag remains. The prefetch engine stays halted until the host issues an explicit `restart`. A restart also clears all history.

The stream side accepts a beat on any cycle where `beat_valid` and `beat_ready` are both high. `beat_ready` is held high, so the block never applies back-pressure, and a sender may hold `beat_valid` for as many cycles as it has beats. The control and status pins are plain levels or single-cycle pulses.

Top module: `prefetch_change_monitor`

## Requirements
- R1: After reset, `prefetch_run` is 1, `irq` is 0, `src_flags` is 0 and `beat_ready` is 1.
- R2: A beat is taken when `beat_valid` and `beat_ready` are both high. Every slot whose offset equals `beat_offset` records `beat_data` as its byte for the current pass. A beat that arrives in the same cycle as `cycle_end` belongs to the pass that is closing.
- R3: When `cycle_end` is high, a slot that saw a byte in that pass and already holds two completed observations fires if `mask & new & prev & ~prev2` is nonzero. Bits with a mask value of 0 never cause a fire.
- R4: History advances only at `cycle_end`. A slot that saw no beat during a pass keeps its previous history unchanged.
- R5: In the cycle after a fire, `prefetch_run` is 0 and `irq` is 1. Bit i of `src_flags` is set exactly for each slot i that fired.
- R6: A fire loads every slot's sampled register at once. A slot that saw a byte in the closing pass stores that byte. Any other slot stores its most recent completed byte, which is 0 if it has never seen one. The sampled registers do not change at any other time.
- R7: `rd_data` shows the sampled register chosen by `rd_sel` in the same cycle. A cycle with `rd_en` high clears bit `rd_sel` of `src_flags`, and reading a slot that is not a source has no effect. `irq` is high while any bit of `src_flags` is set, and it stays high until a read clears it.
- R8: When several slots fire in the same pass, `irq` drops only after every one of their sampled registers has been read.
- R9: While halted, the block ignores beats and `cycle_end`. `prefetch_run` stays 0 after `irq` clears and rises only on an accepted restart.
- R10: A `restart` pulse is accepted only while the block is halted and `irq` is 0; at any other time it is ignored. An accepted restart sets `prefetch_run` and clears all history, so the next fire again needs a full 0, 1, 1 sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_valid | input | 1 | Beat present |
| beat_ready | output | 1 | Beat accepted (always 1) |
| beat_offset | input | OFS_W | Register offset of the beat |
| beat_data | input | DATA_W | Data byte of the beat |
| cycle_end | input | 1 | Pulse that closes the current prefetch pass |
| cfg_offset | input | N*OFS_W | Offset for each slot; slot k uses bits [k*OFS_W +: OFS_W] |
| cfg_mask | input | N*DATA_W | Enabled bits for each slot; slot k uses bits [k*DATA_W +: DATA_W] |
| restart | input | 1 | Host restart pulse |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | SEL_W | Sampled register select |
| rd_data | output | DATA_W | Selected sampled register |
| irq | output | 1 | Interrupt, active high |
| src_flags | output | N | Slots that caused the pending interrupt |
| prefetch_run | output | 1 | 1 lets the periodic prefetch run, 0 halts it |

## Verification
On every cycle, the assertions check four things. A fire halts the engine and raises `irq` on the next edge. `irq` and the halt persist until a read or an accepted restart ends them. A restart during a pending interrupt is ignored. The sampled data and source flags do not move outside a fire.

Only the bench scenarios can show the exact 0, 1, 1 trigger rule across every slot, mask and two-bit value history. The same applies to several other behaviours:
- history being kept across a pass with no matching beat;
- the contents captured for slots that did not fire;
- the need for a fresh 0 after a restart.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  typedef logic [1:0] depth_t;

  // number of completed observations a slot needs before it may fire
  localparam depth_t DEPTH_FULL = 2'd2;

  function automatic logic rise_hold(input logic [7:0] mask,
                                     input logic [7:0] newest,
                                     input logic [7:0] prev,
                                     input logic [7:0] prev2);
    return |(mask & newest & prev & ~prev2);
  endfunction

endpackage

// File: rtl/pcm_slot.sv
module pcm_slot
  import pcm_pkg::*;
#(
  parameter int OFS_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              beat_fire,
  input  logic [OFS_W-1:0]  beat_offset,
  input  logic [DATA_W-1:0] beat_data,
  input  logic [OFS_W-1:0]  cfg_offset,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic              cycle_end,
  input  logic              hist_clear,
  output logic              trig,
  output logic [DATA_W-1:0] snap
);

  logic              hit;
  logic              close;
  logic              seen_q;
  logic              seen_now;
  logic [DATA_W-1:0] cur_q;
  logic [DATA_W-1:0] cur_val;
  logic [DATA_W-1:0] h1_q;
  logic [DATA_W-1:0] h2_q;
  depth_t            depth_q;
  logic [7:0]        m8, n8, p8, q8;

  assign hit      = beat_fire && run && (beat_offset == cfg_offset);
  assign close    = cycle_end && run;
  assign seen_now = seen_q || hit;
  assign cur_val  = hit ? beat_data : cur_q;

  // widen or trim to the byte compare width of the package function
  assign m8 = 8'(cfg_mask);
  assign n8 = 8'(cur_val);
  assign p8 = 8'(h1_q);
  assign q8 = 8'(h2_q);

  assign trig = close && seen_now && (depth_q == DEPTH_FULL) &&
                ((DATA_W <= 8) ? rise_hold(m8, n8, p8, q8)
                               : |(cfg_mask & cur_val & h1_q & ~h2_q));

  assign snap = seen_now ? cur_val : h1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      cur_q   <= '0;
      h1_q    <= '0;
      h2_q    <= '0;
      depth_q <= '0;
    end else if (hist_clear) begin
      seen_q  <= 1'b0;
      cur_q   <= '0;
      h1_q    <= '0;
      h2_q    <= '0;
      depth_q <= '0;
    end else begin
      if (hit) begin
        cur_q  <= beat_data;
        seen_q <= 1'b1;
      end
      if (close) begin
        seen_q <= 1'b0;
        if (seen_now) begin
          h2_q <= h1_q;
          h1_q <= cur_val;
          if (depth_q != DEPTH_FULL) depth_q <= depth_q + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/pcm_ctrl.sv
module pcm_ctrl #(
  parameter int N      = 4,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        trig,
  input  logic [N*DATA_W-1:0] snaps,
  input  logic                restart,
  input  logic                rd_en,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic                run,
  output logic                irq,
  output logic [N-1:0]        src,
  output logic [DATA_W-1:0]   rd_data,
  output logic                hist_clear
);

  logic                run_q;
  logic [N-1:0]        src_q;
  logic [DATA_W-1:0]   samp_q [N];
  logic                sel_ok;
  logic                restart_ok;

  assign sel_ok     = int'(rd_sel) < N;
  assign restart_ok = restart && !run_q && (src_q == '0);
  assign hist_clear = restart_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b1;
      src_q <= '0;
    end else if (|trig) begin
      run_q <= 1'b0;
      src_q <= trig;
    end else begin
      if (rd_en && sel_ok) src_q[rd_sel] <= 1'b0;
      if (restart_ok) run_q <= 1'b1;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_samp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     samp_q[k] <= '0;
      else if (|trig) samp_q[k] <= snaps[k*DATA_W +: DATA_W];
    end
  end

  assign run     = run_q;
  assign src     = src_q;
  assign irq     = |src_q;
  assign rd_data = sel_ok ? samp_q[rd_sel] : '0;

endmodule

// File: rtl/prefetch_change_monitor.sv
module prefetch_change_monitor #(
  parameter int N      = 4,
  parameter int OFS_W  = 8,
  parameter int DATA_W = 8,
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                beat_valid,
  output logic                beat_ready,
  input  logic [OFS_W-1:0]    beat_offset,
  input  logic [DATA_W-1:0]   beat_data,
  input  logic                cycle_end,
  input  logic [N*OFS_W-1:0]  cfg_offset,
  input  logic [N*DATA_W-1:0] cfg_mask,
  input  logic                restart,
  input  logic                rd_en,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [DATA_W-1:0]   rd_data,
  output logic                irq,
  output logic [N-1:0]        src_flags,
  output logic                prefetch_run
);

  logic                beat_fire;
  logic                hist_clear;
  logic [N-1:0]        trig_vec;
  logic [N*DATA_W-1:0] snap_vec;

  assign beat_ready = 1'b1;
  assign beat_fire  = beat_valid && beat_ready;

  for (genvar k = 0; k < N; k++) begin : g_slot
    pcm_slot #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (prefetch_run),
      .beat_fire  (beat_fire),
      .beat_offset(beat_offset),
      .beat_data  (beat_data),
      .cfg_offset (cfg_offset[k*OFS_W +: OFS_W]),
      .cfg_mask   (cfg_mask[k*DATA_W +: DATA_W]),
      .cycle_end  (cycle_end),
      .hist_clear (hist_clear),
      .trig       (trig_vec[k]),
      .snap       (snap_vec[k*DATA_W +: DATA_W])
    );
  end

  pcm_ctrl #(.N(N), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig_vec),
    .snaps     (snap_vec),
    .restart   (restart),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .run       (prefetch_run),
    .irq       (irq),
    .src       (src_flags),
    .rd_data   (rd_data),
    .hist_clear(hist_clear)
  );

endmodule

// File: rtl/pcm_chk.sv
module pcm_chk #(
  parameter int N      = 4,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      trig,
  input logic              run,
  input logic              irq,
  input logic [N-1:0]      src,
  input logic              restart,
  input logic              rd_en,
  input logic [SEL_W-1:0]  rd_sel,
  input logic [DATA_W-1:0] rd_data
);

  // R5
  fire_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig) |=> (irq && !run));

  // R7
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_en) |=> irq);

  // R8
  src_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !rd_en) |=> $stable(src));

  // R9
  halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> !run);

  // R10
  restart_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && restart) |=> !run);

  // R6
  sample_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_sel) && !$past(|trig)) |-> $stable(rd_data));

endmodule

bind prefetch_change_monitor pcm_chk #(.N(N), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .trig   (trig_vec),
  .run    (prefetch_run),
  .irq    (irq),
  .src    (src_flags),
  .restart(restart),
  .rd_en  (rd_en),
  .rd_sel (rd_sel),
  .rd_data(rd_data)
);

// File: tb/tb_prefetch_change_monitor.sv
module tb_prefetch_change_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int OFS_W = 8;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              beat_valid = 1'b0;
  logic              beat_ready;
  logic [OFS_W-1:0]  beat_offset = '0;
  logic [DATA_W-1:0] beat_data = '0;
  logic              cycle_end = 1'b0;
  logic [N*OFS_W-1:0]  cfg_offset;
  logic [N*DATA_W-1:0] cfg_mask = '0;
  logic              restart = 1'b0;
  logic              rd_en = 1'b0;
  logic [1:0]        rd_sel = '0;
  logic [DATA_W-1:0] rd_data;
  logic              irq;
  logic [N-1:0]      src_flags;
  logic              prefetch_run;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // slot k watches offset 0x10*(k+1)
  assign cfg_offset = {8'h40, 8'h30, 8'h20, 8'h10};

  prefetch_change_monitor dut (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_offset(beat_offset), .beat_data(beat_data), .cycle_end(cycle_end),
    .cfg_offset(cfg_offset), .cfg_mask(cfg_mask), .restart(restart),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq),
    .src_flags(src_flags), .prefetch_run(prefetch_run)
  );

  function automatic logic [7:0] ofs(input int k);
    return 8'(8'h10 * (k + 1));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; beat_valid = 0; cycle_end = 0; restart = 0; rd_en = 0; rd_sel = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic beat(input logic [7:0] o, input logic [7:0] d, input logic last);
    beat_valid = 1'b1; beat_offset = o; beat_data = d; cycle_end = last;
    @(negedge clk);
    beat_valid = 1'b0; cycle_end = 1'b0;
  endtask

  task automatic cend();
    cycle_end = 1'b1;
    @(negedge clk);
    cycle_end = 1'b0;
  endtask

  task automatic pulse_restart();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic host_read(input int sel, output logic [7:0] d);
    rd_sel = 2'(sel); rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    do_reset();
    // R1 reset state
    chk("R1 run", prefetch_run, 1);
    chk("R1 irq", irq, 0);
    chk("R1 src", src_flags, 0);
    chk("R1 ready", beat_ready, 1);

    // R3 sweep: every slot, masks 1..3, all two-bit value histories
    for (int k = 0; k < N; k++) begin
      for (int m = 1; m < 4; m++) begin
        for (int s = 0; s < 64; s++) begin
          logic [7:0] v0, v1, v2;
          logic exp;
          v0 = 8'(s & 3); v1 = 8'((s >> 2) & 3); v2 = 8'((s >> 4) & 3);
          exp = |(8'(m) & v2 & v1 & ~v0);
          do_reset();
          cfg_mask = '0;
          cfg_mask[k*8 +: 8] = 8'(m);
          beat(ofs(k), v0, 0); beat(8'h99, 8'hFF, 0); cend();
          beat(ofs(k), v1, 0); beat(8'h99, 8'hFF, 0); cend();
          chk("R3 early", irq, 0);
          beat(ofs(k), v2, 0); beat(8'h99, 8'hFF, 0); cend();
          chk("R3 fire", irq, 32'(exp));
          chk("R5 src", src_flags, exp ? (32'd1 << k) : 0);
          chk("R5 run", prefetch_run, 32'(!exp));
          if (exp) begin
            host_read(k, d);
            chk("R7 data", d, v2);
            chk("R7 clear", irq, 0);
            chk("R9 halted", prefetch_run, 0);
          end
        end
      end
    end

    // R4 absent pass keeps history; R2 beat with cycle_end belongs to closing pass
    do_reset();
    cfg_mask = 32'h0000_0001;
    beat(ofs(0), 8'h00, 0); cend();
    cend();
    chk("R4 gap", irq, 0);
    beat(ofs(0), 8'h01, 0); cend();
    chk("R4 depth", irq, 0);
    beat(ofs(0), 8'h01, 1);
    chk("R2 same-cycle", irq, 1);
    chk("R2 src", src_flags, 4'b0001);

    // R8 multi-source, R6 capture, R10 blocked restart
    do_reset();
    cfg_mask = 32'h0000_8080;
    beat(ofs(0), 8'h00, 0); beat(ofs(1), 8'h00, 0); beat(ofs(2), 8'h11, 0); cend();
    beat(ofs(0), 8'h80, 0); beat(ofs(1), 8'h80, 0); beat(ofs(2), 8'h22, 0); cend();
    beat(ofs(0), 8'h81, 0); beat(ofs(1), 8'hC0, 0); beat(ofs(2), 8'hA5, 0); cend();
    chk("R8 src", src_flags, 4'b0011);
    host_read(2, d);
    chk("R6 other slot", d, 8'hA5);
    chk("R7 non-source read", irq, 1);
    host_read(3, d);
    chk("R6 unseen slot", d, 8'h00);
    host_read(0, d);
    chk("R6 slot0", d, 8'h81);
    chk("R8 still pending", irq, 1);
    pulse_restart();
    chk("R10 blocked", prefetch_run, 0);
    host_read(1, d);
    chk("R6 slot1", d, 8'hC0);
    chk("R8 cleared", irq, 0);
    chk("R9 stay halted", prefetch_run, 0);

    // R9 halted beats ignored
    beat(ofs(0), 8'h00, 1);
    beat(ofs(0), 8'h80, 1);
    beat(ofs(0), 8'h80, 1);
    chk("R9 ignored", irq, 0);
    host_read(0, d);
    chk("R9 sample kept", d, 8'h81);

    // R10 restart clears history
    pulse_restart();
    chk("R10 run", prefetch_run, 1);
    beat(ofs(0), 8'h80, 1);
    beat(ofs(0), 8'h80, 1);
    beat(ofs(0), 8'h80, 1);
    chk("R10 needs zero", irq, 0);
    beat(ofs(0), 8'h00, 1);
    beat(ofs(0), 8'h80, 1);
    chk("R10 partial", irq, 0);
    beat(ofs(0), 8'h80, 1);
    chk("R10 fresh fire", irq, 1);

    finish_run();
  end

endmodule